// File: doc/BRIEF.md
# Operand Hazard and Bypass Controller

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It keeps a compact record of the destination register, write flag and load flag of the three instructions downstream of decode. Each cycle it compares the two source register numbers of the instruction now in decode against that record. From the comparison it produces one bypass select per source operand and a single stall line.

When stall is high, the surrounding pipeline keeps its program counter and fetch/decode register unchanged. The controller places a non-writing bubble into its own execute slot. Branches have one architectural delay slot. The controller has no flush or squash output, so the slot instruction always advances like any other instruction.

The `BYPASS` parameter selects between two variants. With bypass enabled, results are taken from execute, memory or writeback, and only a load whose consumer follows it directly is delayed. With bypass disabled, every select stays on the register file, and a consumer waits in decode until its producer has left writeback.

Top module: `hazard_ctrl`

## Requirements
- R1: After reset no downstream slot holds a writer: with any decode operands, stall is 0 and both selects are 0 until an instruction that writes has entered execute.
- R2: Select encoding is 0 = register file, 1 = execute result, 2 = memory-stage result (ALU or load data), 3 = writeback value. With bypass enabled, a consumer placed 1, 2 or 3 positions after a non-load producer gets select 1, 2 or 3 without stalling, and at 4 or more positions it gets 0.
- R3: When several downstream slots write the register an operand reads, the select names the youngest one (execute over memory over writeback). A younger non-load writer also hides an older load, so no stall occurs.
- R4: With bypass enabled, a load followed directly by a reader of its destination costs exactly one stall cycle. During that cycle a bubble enters execute, and in the next cycle the reader is released with select 2. A load two or more positions ahead causes no stall.
- R5: A source register number of 0 never matches: it never stalls and always selects 0, even when a downstream writer has destination 0.
- R6: A downstream slot whose write flag is low, such as a store, a branch or a bubble, never matches, whatever its destination field holds. The instruction after a branch is never stalled or removed on the branch's account.
- R7: An operand whose read flag is low never matches and keeps select 0.
- R8: With bypass disabled, both selects stay 0. A reader stalls while its producer is in execute, memory or writeback: 3 stall cycles right after the producer, then 2, then 1, and 0 at four or more positions.
- R9: The two operands are resolved independently: in one cycle the rs select and the rt select may name different stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_rs | input | REG_W | First source register number of the decode instruction |
| dec_rt | input | REG_W | Second source register number of the decode instruction |
| dec_rs_rd | input | 1 | The decode instruction reads dec_rs |
| dec_rt_rd | input | 1 | The decode instruction reads dec_rt |
| dec_rd | input | REG_W | Destination register number of the decode instruction |
| dec_wr | input | 1 | The decode instruction writes dec_rd |
| dec_load | input | 1 | The decode instruction is a load |
| fwd_rs | output | 2 | Bypass select for the first operand |
| fwd_rt | output | 2 | Bypass select for the second operand |
| stall | output | 1 | Hold PC and fetch/decode register; bubble into execute |

## Verification
The assertions assume the surrounding pipeline obeys stall: it presents the same decode instruction again after a stalled cycle and gives every instruction consistent read, write and load flags. The property that a stall never lasts beyond one cycle in bypass mode depends on that hold behaviour. The stimulus drives one instruction at a time and repeats it while stall is high. It inserts only whole instructions or no-operations with all flags low, so the record seen by the assertions always matches a legal instruction stream.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
   // downstream slots tracked behind decode: execute, memory, writeback
   localparam int unsigned LATE_STAGES = 3;

   typedef enum logic [1:0] {
      SRC_RF  = 2'd0,
      SRC_EX  = 2'd1,
      SRC_MEM = 2'd2,
      SRC_WB  = 2'd3
   } fwd_src_e;
endpackage

// File: rtl/hz_stage_track.sv
`timescale 1ns/1ps
// Shadow record of destination, write flag and load flag for the slots
// behind decode. Index 0 is execute; higher indices are older.
module hz_stage_track #(
   parameter int unsigned REG_W = 5,
   parameter int unsigned DEPTH = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         hold_i,
   input  logic [REG_W-1:0]             rd_i,
   input  logic                         wr_i,
   input  logic                         load_i,
   output logic [DEPTH-1:0][REG_W-1:0]  rd_o,
   output logic [DEPTH-1:0]             wr_o,
   output logic                         ex_load_o
);
   logic [DEPTH-1:0][REG_W-1:0] rd_q;
   logic [DEPTH-1:0]            wr_q;
   logic                        ld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
         wr_q <= '0;
         ld_q <= 1'b0;
      end else begin
         for (int s = DEPTH - 1; s > 0; s--) begin
            rd_q[s] <= rd_q[s-1];
            wr_q[s] <= wr_q[s-1];
         end
         // a held decode slot sends a non-writing bubble into execute
         rd_q[0] <= hold_i ? '0 : rd_i;
         wr_q[0] <= wr_i && !hold_i;
         ld_q    <= load_i && !hold_i;
      end
   end

   assign rd_o      = rd_q;
   assign wr_o      = wr_q;
   assign ex_load_o = ld_q;
endmodule

// File: rtl/hz_operand_match.sv
`timescale 1ns/1ps
// Resolves one source operand against the downstream record.
module hz_operand_match
   import hz_pkg::*;
#(
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DEPTH  = 3,
   parameter bit          BYPASS = 1'b1
) (
   input  logic [REG_W-1:0]             src_i,
   input  logic                         used_i,
   input  logic [DEPTH-1:0][REG_W-1:0]  rd_i,
   input  logic [DEPTH-1:0]             wr_i,
   input  logic                         ex_load_i,
   output fwd_src_e                     sel_o,
   output logic                         stall_o
);
   logic             live;
   logic [DEPTH-1:0] hit;

   // register zero is hard-wired and never a dependency
   assign live = used_i && (src_i != '0);

   for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
      assign hit[s] = live && wr_i[s] && (rd_i[s] == src_i);
   end

   if (BYPASS) begin : g_fwd
      always_comb begin
         sel_o = SRC_RF;
         // scan oldest to youngest so the youngest hit wins
         for (int s = DEPTH - 1; s >= 0; s--) begin
            if (hit[s]) sel_o = fwd_src_e'(2'(s + 1));
         end
      end
      // load data is not ready while the load is still in execute
      assign stall_o = hit[0] && ex_load_i;
   end else begin : g_wait
      logic unused_ex_load;
      assign unused_ex_load = ex_load_i;
      assign sel_o   = SRC_RF;
      assign stall_o = |hit;
   end
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
module hazard_ctrl
   import hz_pkg::*;
#(
   parameter int unsigned REG_W  = 5,
   parameter bit          BYPASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] dec_rs,
   input  logic [REG_W-1:0] dec_rt,
   input  logic             dec_rs_rd,
   input  logic             dec_rt_rd,
   input  logic [REG_W-1:0] dec_rd,
   input  logic             dec_wr,
   input  logic             dec_load,
   output logic [1:0]       fwd_rs,
   output logic [1:0]       fwd_rt,
   output logic             stall
);
   localparam int unsigned DEPTH = LATE_STAGES;
   localparam int unsigned NOPS  = 2;

   if (REG_W < 2 || REG_W > 8) begin : g_bad_width
      $error("hazard_ctrl: REG_W must lie in 2..8");
   end
   if (DEPTH != 3) begin : g_bad_depth
      $error("hazard_ctrl: select encoding assumes three downstream slots");
   end

   logic [DEPTH-1:0][REG_W-1:0] trk_rd;
   logic [DEPTH-1:0]            trk_wr;
   logic                        trk_ld;

   logic [NOPS-1:0][REG_W-1:0]  op_src;
   logic [NOPS-1:0]             op_used;
   fwd_src_e                    op_sel [NOPS];
   logic [NOPS-1:0]             op_stall;

   assign op_src  = {dec_rt, dec_rs};
   assign op_used = {dec_rt_rd, dec_rs_rd};

   hz_stage_track #(
      .REG_W (REG_W),
      .DEPTH (DEPTH)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_i    (stall),
      .rd_i      (dec_rd),
      .wr_i      (dec_wr),
      .load_i    (dec_load),
      .rd_o      (trk_rd),
      .wr_o      (trk_wr),
      .ex_load_o (trk_ld)
   );

   for (genvar k = 0; k < NOPS; k++) begin : g_op
      hz_operand_match #(
         .REG_W  (REG_W),
         .DEPTH  (DEPTH),
         .BYPASS (BYPASS)
      ) u_match (
         .src_i     (op_src[k]),
         .used_i    (op_used[k]),
         .rd_i      (trk_rd),
         .wr_i      (trk_wr),
         .ex_load_i (trk_ld),
         .sel_o     (op_sel[k]),
         .stall_o   (op_stall[k])
      );
   end

   assign stall  = |op_stall;
   assign fwd_rs = op_sel[0];
   assign fwd_rt = op_sel[1];
endmodule

// File: rtl/hazard_ctrl_chk.sv
`timescale 1ns/1ps
module hazard_ctrl_chk #(
   parameter int unsigned REG_W  = 5,
   parameter bit          BYPASS = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [REG_W-1:0]       dec_rs,
   input logic [REG_W-1:0]       dec_rt,
   input logic                   dec_rs_rd,
   input logic                   dec_rt_rd,
   input logic [1:0]             fwd_rs,
   input logic [1:0]             fwd_rt,
   input logic                   stall,
   input logic [2:0][REG_W-1:0]  stg_rd,
   input logic [2:0]             stg_wr,
   input logic                   ex_load
);
   // R2
   ex_sel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_rs == 2'd1) |-> (dec_rs_rd && stg_wr[0] && stg_rd[0] == dec_rs));

   // R3
   mem_sel_youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_rs == 2'd2) |-> !(stg_wr[0] && stg_rd[0] == dec_rs));

   // R3
   wb_sel_youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_rt == 2'd3) |-> !(stg_wr[1] && stg_rd[1] == dec_rt) && !(stg_wr[0] && stg_rd[0] == dec_rt));

   // R4
   single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS && stall) |=> !stall);

   // R4
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS && stall) |-> (ex_load && stg_wr[0]));

   // R4
   bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stg_wr[0]);

   // R5
   zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_rs == '0) |-> (fwd_rs == 2'd0));

   // R7
   unread_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_rt_rd |-> (fwd_rt == 2'd0));

   // R8
   wait_for_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!BYPASS && dec_rs_rd && dec_rs != '0 && stg_wr[2] && stg_rd[2] == dec_rs) |-> stall);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(
   .REG_W  (REG_W),
   .BYPASS (BYPASS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dec_rs    (dec_rs),
   .dec_rt    (dec_rt),
   .dec_rs_rd (dec_rs_rd),
   .dec_rt_rd (dec_rt_rd),
   .fwd_rs    (fwd_rs),
   .fwd_rt    (fwd_rt),
   .stall     (stall),
   .stg_rd    (trk_rd),
   .stg_wr    (trk_wr),
   .ex_load   (trk_ld)
);

// File: tb/hazard_ctrl_test.sv
`timescale 1ns/1ps
module hazard_ctrl_test;
   localparam int RW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [RW-1:0] d_rs = '0, d_rt = '0, d_rd = '0;
   logic          d_rs_rd = 1'b0, d_rt_rd = 1'b0, d_wr = 1'b0, d_ld = 1'b0;
   logic [1:0]    b_rs, b_rt, n_rs, n_rt;
   logic          b_st, n_st;

   int checks = 0;
   int fails  = 0;
   bit mode_nb = 1'b0;

   hazard_ctrl #(.REG_W(RW), .BYPASS(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .dec_rs(d_rs), .dec_rt(d_rt),
      .dec_rs_rd(d_rs_rd), .dec_rt_rd(d_rt_rd), .dec_rd(d_rd),
      .dec_wr(d_wr), .dec_load(d_ld), .fwd_rs(b_rs), .fwd_rt(b_rt), .stall(b_st));

   hazard_ctrl #(.REG_W(RW), .BYPASS(1'b0)) uut_nb (
      .clk(clk), .rst_n(rst_n), .dec_rs(d_rs), .dec_rt(d_rt),
      .dec_rs_rd(d_rs_rd), .dec_rt_rd(d_rt_rd), .dec_rd(d_rd),
      .dec_wr(d_wr), .dec_load(d_ld), .fwd_rs(n_rs), .fwd_rt(n_rt), .stall(n_st));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (mode %s)", tag, act, exp,
                  mode_nb ? "no-bypass" : "bypass");
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // present one instruction, repeating it while the observed DUT stalls
   task automatic issue(input logic [RW-1:0] rs, input logic [RW-1:0] rt,
                        input bit rsu, input bit rtu, input logic [RW-1:0] rd,
                        input bit wr, input bit ld,
                        output int stalls, output int srs, output int srt);
      stalls = 0;
      srs = -1;
      srt = -1;
      while (1'b1) begin
         @(negedge clk);
         d_rs = rs; d_rt = rt; d_rs_rd = rsu; d_rt_rd = rtu;
         d_rd = rd; d_wr = wr; d_ld = ld;
         #2;
         if (mode_nb ? n_st : b_st) begin
            stalls++;
            if (stalls > 8) break;
         end else begin
            srs = int'(mode_nb ? n_rs : b_rs);
            srt = int'(mode_nb ? n_rt : b_rt);
            break;
         end
      end
   endtask

   task automatic producer(input logic [RW-1:0] rd, input bit wr, input bit ld);
      int s, a, b;
      issue('0, '0, 1'b0, 1'b0, rd, wr, ld, s, a, b);
   endtask

   task automatic nops(input int n);
      for (int i = 0; i < n; i++) producer('0, 1'b0, 1'b0);
   endtask

   function automatic int exp_stalls(bit nb, bit ld, int g);
      if (nb) return (g < 3) ? 3 - g : 0;
      return (ld && g == 0) ? 1 : 0;
   endfunction

   function automatic int exp_sel(bit nb, bit ld, int g);
      if (nb) return 0;
      if (g == 0) return ld ? 2 : 1;
      if (g < 3) return g + 1;
      return 0;
   endfunction

   initial begin
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      summary();
      $finish;
   end

   initial begin
      int st, sa, sb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      d_rs = 5'd3; d_rt = 5'd3; d_rs_rd = 1'b1; d_rt_rd = 1'b1;
      #2;
      // R1: empty record after reset
      check("R1 stall bypass", int'(b_st), 0);
      check("R1 rs bypass", int'(b_rs), 0);
      check("R1 stall no-bypass", int'(n_st), 0);
      check("R1 rt no-bypass", int'(n_rt), 0);

      // R2 R4 R8 R9 sweep: producer kind x distance x variant
      for (int nb = 0; nb < 2; nb++) begin
         for (int ld = 0; ld < 2; ld++) begin
            for (int g = 0; g < 4; g++) begin
               string tg;
               mode_nb = bit'(nb);
               tg = nb != 0 ? "R8" : (ld != 0 ? "R4" : "R2");
               nops(3);
               producer(5'd3, 1'b1, bit'(ld));
               nops(g);
               if (g % 2 == 0) begin
                  issue(5'd3, 5'd4, 1'b1, 1'b1, 5'd5, 1'b1, 1'b0, st, sa, sb);
               end else begin
                  issue(5'd4, 5'd3, 1'b1, 1'b1, 5'd5, 1'b1, 1'b0, st, sb, sa);
               end
               check({tg, " stall count"}, st, exp_stalls(bit'(nb), bit'(ld), g));
               check({tg, " matched select"}, sa, exp_sel(bit'(nb), bit'(ld), g));
               check("R9 other operand select", sb, 0);
            end
         end
      end

      for (int nb = 0; nb < 2; nb++) begin
         mode_nb = bit'(nb);
         // R5: register zero never matches, even against a load to r0
         nops(3);
         producer('0, 1'b1, 1'b1);
         issue('0, '0, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0, st, sa, sb);
         check("R5 stall", st, 0);
         check("R5 rs select", sa, 0);
         check("R5 rt select", sb, 0);
         // R6: branch (no write, equal destination field) then its delay slot
         nops(3);
         issue(5'd3, '0, 1'b1, 1'b0, 5'd3, 1'b0, 1'b0, st, sa, sb);
         issue(5'd3, 5'd3, 1'b1, 1'b1, 5'd7, 1'b1, 1'b0, st, sa, sb);
         check("R6 delay slot stall", st, 0);
         check("R6 delay slot select", sa, 0);
         // R7: operand fields match but read flags are low
         nops(3);
         producer(5'd3, 1'b1, 1'b0);
         issue(5'd3, 5'd3, 1'b0, 1'b0, 5'd8, 1'b1, 1'b0, st, sa, sb);
         check("R7 stall", st, 0);
         check("R7 rs select", sa, 0);
         check("R7 rt select", sb, 0);
      end

      mode_nb = 1'b0;
      // R3: two writers of r3, younger in execute
      nops(3);
      producer(5'd3, 1'b1, 1'b1);
      producer(5'd3, 1'b1, 1'b0);
      issue(5'd3, '0, 1'b1, 1'b0, 5'd9, 1'b1, 1'b0, st, sa, sb);
      check("R3 younger ALU hides load stall", st, 0);
      check("R3 execute wins", sa, 1);
      // R3: two writers of r3 in memory and writeback
      nops(3);
      producer(5'd3, 1'b1, 1'b0);
      producer(5'd3, 1'b1, 1'b0);
      nops(1);
      issue('0, 5'd3, 1'b0, 1'b1, 5'd9, 1'b1, 1'b0, st, sa, sb);
      check("R3 memory wins over writeback", sb, 2);
      // R9: rs from execute, rt from memory in the same cycle
      nops(3);
      producer(5'd3, 1'b1, 1'b0);
      producer(5'd4, 1'b1, 1'b0);
      issue(5'd4, 5'd3, 1'b1, 1'b1, 5'd10, 1'b1, 1'b0, st, sa, sb);
      check("R9 rs select", sa, 1);
      check("R9 rt select", sb, 2);
      // R4: load read by both operands
      nops(3);
      producer(5'd3, 1'b1, 1'b1);
      issue(5'd3, 5'd3, 1'b1, 1'b1, 5'd11, 1'b1, 1'b0, st, sa, sb);
      check("R4 both operands stall", st, 1);
      check("R4 both operands rs", sa, 2);
      check("R4 both operands rt", sb, 2);

      summary();
      $finish;
   end
endmodule